// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU with a 16-bit address bus and a cartridge holding a ROM of up to 2 MB and a banked RAM. The cartridge ROM cannot be written, so CPU writes that land in the lower 32 KB of the address space are taken as writes to control registers. These registers hold a 5-bit ROM bank number, a 2-bit field and a banking-mode bit. Depending on the mode, the 2-bit field supplies either the top ROM address bits or the RAM bank number. A fourth register turns the external RAM on and off.

For each CPU read the block produces, one clock later, a flat byte offset into the ROM or the RAM. It also produces flags that tell the surrounding data path what to return instead of the stored byte. A ROM offset at or beyond the configured ROM size must read as 0x00. A RAM read while the RAM is disabled must read as 0xFF. Each update of a bank register raises a one-cycle pulse for observation.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank register is 1, the 2-bit field is 0, the mode bit is 0 (ROM banking), the RAM is disabled, and every output is 0.
- R2: A write to 0x2000–0x3FFF loads the ROM bank register from data bits 4:0. A written value of 0 is stored as 1, and any other value is stored unchanged. The cycle after the write, rom_bank_upd is high for one cycle.
- R3: A write to 0x4000–0x5FFF loads the 2-bit field from data bits 1:0. The cycle after the write, ram_bank_upd is high for one cycle.
- R4: A write to 0x6000–0x7FFF sets the mode bit from data bit 0: 0 selects ROM banking and 1 selects RAM banking.
- R5: A read of 0x0000–0x3FFF raises rom_hit one cycle later, with rom_off equal to addr[13:0] and all higher bits 0.
- R6: A read of 0x4000–0x7FFF raises rom_hit one cycle later. rom_off is {field, bank, addr[13:0]}, with the field in bits 20:19 and the bank in bits 18:14. In RAM-banking mode, bits 20:19 are 0.
- R7: When a ROM read's offset is greater than or equal to rom_size, rom_zero is high alongside rom_hit, so the read returns 0x00. Otherwise rom_zero is low.
- R8: A write to 0x0000–0x1FFF enables the RAM when data bits 3:0 equal 0xA, and disables it for any other value.
- R9: A read of 0xA000–0xBFFF raises ram_hit one cycle later. ram_off is {field, addr[12:0]} in RAM-banking mode and {2'b00, addr[12:0]} in ROM-banking mode. ram_blocked is high when the RAM was disabled, so the read returns 0xFF.
- R10: A read of any other address leaves rom_hit, ram_hit, rom_zero and ram_blocked low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| rom_size | input | 22 | ROM size in bytes |
| rom_hit | output | 1 | Previous cycle's read targeted ROM |
| rom_off | output | 21 | Flat ROM byte offset |
| rom_zero | output | 1 | ROM read is out of range and returns 0x00 |
| ram_hit | output | 1 | Previous cycle's read targeted RAM |
| ram_off | output | 15 | Flat RAM byte offset |
| ram_blocked | output | 1 | RAM read while disabled, returns 0xFF |
| rom_bank_upd | output | 1 | Pulse after a ROM bank register write |
| ram_bank_upd | output | 1 | Pulse after a 2-bit field write |

## Verification
The bench builds the block with its default parameters: a 5-bit bank, a 2-bit field, a 16 KB window and an 8 KB RAM window, giving a full 21-bit ROM offset. It runs the same stimulus against two rom_size values. With the full 2 MB, no offset is ever out of range. With 256 KB, any bank of 16 or above, and any nonzero upper field in ROM-banking mode, reaches the zero-return path, and the last byte below the limit and the first byte at the limit can be placed on either side of the boundary.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Which control register a CPU write addresses
  typedef enum logic [2:0] {
    WS_NONE,
    WS_RAMEN,
    WS_BANK,
    WS_FIELD,
    WS_MODE
  } wsel_e;

  // Which window a CPU read addresses
  typedef enum logic [1:0] {
    RW_NONE,
    RW_ROM_FIXED,
    RW_ROM_SWITCH,
    RW_RAM
  } rwin_e;

  // The top three address bits select an 8 KB region
  function automatic wsel_e decode_write(input logic [2:0] top3);
    case (top3)
      3'b000:  return WS_RAMEN;
      3'b001:  return WS_BANK;
      3'b010:  return WS_FIELD;
      3'b011:  return WS_MODE;
      default: return WS_NONE;
    endcase
  endfunction

  function automatic rwin_e decode_read(input logic [2:0] top3);
    case (top3)
      3'b000, 3'b001: return RW_ROM_FIXED;
      3'b010, 3'b011: return RW_ROM_SWITCH;
      3'b101:         return RW_RAM;
      default:        return RW_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int HI_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [15:0]       addr,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] bank,
  output logic [HI_W-1:0]   field,
  output logic              mode,
  output logic              ram_en,
  output logic              bank_upd,
  output logic              field_upd
);

  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  wsel_e             sel;
  logic [BANK_W-1:0] bank_in;

  always_comb begin
    sel     = wr ? decode_write(addr[15:13]) : WS_NONE;
    bank_in = (wdata[BANK_W-1:0] == '0) ? BANK_ONE : wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank      <= BANK_ONE;
      field     <= '0;
      mode      <= 1'b0;
      ram_en    <= 1'b0;
      bank_upd  <= 1'b0;
      field_upd <= 1'b0;
    end else begin
      bank_upd  <= (sel == WS_BANK);
      field_upd <= (sel == WS_FIELD);
      case (sel)
        WS_RAMEN: ram_en <= (wdata[3:0] == 4'hA);
        WS_BANK:  bank   <= bank_in;
        WS_FIELD: field  <= wdata[HI_W-1:0];
        WS_MODE:  mode   <= wdata[0];
        default:  ;
      endcase
    end
  end

  // R2: a zero bank write selects bank one
  assert_zero_bank_is_one_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:13] == 3'b001 && wdata[BANK_W-1:0] == '0) |=> (bank == BANK_ONE));

  // R2: the bank register never holds zero
  assert_bank_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    bank != '0);

  // R3: a field write is followed by a one-cycle update pulse
  assert_field_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:13] == 3'b010) |=> (field_upd && field == $past(wdata[HI_W-1:0])));

  // R8: the RAM enable follows the key nibble
  assert_ram_key_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && addr[15:13] == 3'b000) |=> (ram_en == ($past(wdata[3:0]) == 4'hA)));

endmodule

// File: rtl/cbc_map.sv
module cbc_map
  import cbc_pkg::*;
#(
  parameter int BANK_W    = 5,
  parameter int HI_W      = 2,
  parameter int WIN_W     = 14,
  parameter int RAM_WIN_W = 13,
  localparam int ROM_OFF_W = HI_W + BANK_W + WIN_W,
  localparam int RAM_OFF_W = HI_W + RAM_WIN_W,
  localparam int SIZE_W    = ROM_OFF_W + 1
) (
  input  logic [15:0]          addr,
  input  logic [BANK_W-1:0]    bank,
  input  logic [HI_W-1:0]      field,
  input  logic                 mode,
  input  logic [SIZE_W-1:0]    rom_size,
  output rwin_e                win,
  output logic [ROM_OFF_W-1:0] rom_off,
  output logic                 rom_oob,
  output logic [RAM_OFF_W-1:0] ram_off
);

  logic [HI_W-1:0] rom_hi;
  logic [HI_W-1:0] ram_hi;

  always_comb begin
    win    = decode_read(addr[15:13]);
    // Mode 1 routes the field to RAM, mode 0 to the ROM upper bits
    rom_hi = mode ? '0 : field;
    ram_hi = mode ? field : '0;

    if (win == RW_ROM_SWITCH)
      rom_off = {rom_hi, bank, addr[WIN_W-1:0]};
    else
      rom_off = {{(HI_W + BANK_W){1'b0}}, addr[WIN_W-1:0]};

    rom_oob = ({1'b0, rom_off} >= rom_size);
    ram_off = {ram_hi, addr[RAM_WIN_W-1:0]};
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int BANK_W    = 5,
  parameter int HI_W      = 2,
  parameter int WIN_W     = 14,
  parameter int RAM_WIN_W = 13,
  localparam int ROM_OFF_W = HI_W + BANK_W + WIN_W,
  localparam int RAM_OFF_W = HI_W + RAM_WIN_W,
  localparam int SIZE_W    = ROM_OFF_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          cpu_addr,
  input  logic                 cpu_wr,
  input  logic                 cpu_rd,
  input  logic [7:0]           cpu_wdata,
  input  logic [SIZE_W-1:0]    rom_size,
  output logic                 rom_hit,
  output logic [ROM_OFF_W-1:0] rom_off,
  output logic                 rom_zero,
  output logic                 ram_hit,
  output logic [RAM_OFF_W-1:0] ram_off,
  output logic                 ram_blocked,
  output logic                 rom_bank_upd,
  output logic                 ram_bank_upd
);

  logic [BANK_W-1:0]    bank;
  logic [HI_W-1:0]      field;
  logic                 mode;
  logic                 ram_en;
  rwin_e                win;
  logic [ROM_OFF_W-1:0] rom_off_c;
  logic                 rom_oob_c;
  logic [RAM_OFF_W-1:0] ram_off_c;
  logic                 is_rom;
  logic                 is_ram;

  cbc_regs #(.BANK_W(BANK_W), .HI_W(HI_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (cpu_wr),
    .addr      (cpu_addr),
    .wdata     (cpu_wdata),
    .bank      (bank),
    .field     (field),
    .mode      (mode),
    .ram_en    (ram_en),
    .bank_upd  (rom_bank_upd),
    .field_upd (ram_bank_upd)
  );

  cbc_map #(
    .BANK_W(BANK_W), .HI_W(HI_W), .WIN_W(WIN_W), .RAM_WIN_W(RAM_WIN_W)
  ) u_map (
    .addr     (cpu_addr),
    .bank     (bank),
    .field    (field),
    .mode     (mode),
    .rom_size (rom_size),
    .win      (win),
    .rom_off  (rom_off_c),
    .rom_oob  (rom_oob_c),
    .ram_off  (ram_off_c)
  );

  always_comb begin
    is_rom = cpu_rd && (win == RW_ROM_FIXED || win == RW_ROM_SWITCH);
    is_ram = cpu_rd && (win == RW_RAM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_hit     <= 1'b0;
      rom_off     <= '0;
      rom_zero    <= 1'b0;
      ram_hit     <= 1'b0;
      ram_off     <= '0;
      ram_blocked <= 1'b0;
    end else begin
      rom_hit     <= is_rom;
      rom_zero    <= is_rom && rom_oob_c;
      ram_hit     <= is_ram;
      ram_blocked <= is_ram && !ram_en;
      if (is_rom) rom_off <= rom_off_c;
      if (is_ram) ram_off <= ram_off_c;
    end
  end

  // R7: zero-return only on a ROM read whose offset reaches the size
  assert_zero_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    rom_zero |-> (rom_hit && ({1'b0, rom_off} >= $past(rom_size))));

  // R9: blocked RAM read only when the RAM was disabled
  assert_blocked_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    ram_blocked |-> (ram_hit && !$past(ram_en)));

  // R10: a read reaches at most one store
  assert_one_target_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_hit, ram_hit}));

  // R5: a fixed-window read never carries bank bits
  assert_fixed_window_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:14] == 2'b00) |=> (rom_hit && rom_off[ROM_OFF_W-1:WIN_W] == '0));

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic        cpu_wr;
  logic        cpu_rd;
  logic [7:0]  cpu_wdata;
  logic [21:0] rom_size;
  logic        rom_hit;
  logic [20:0] rom_off;
  logic        rom_zero;
  logic        ram_hit;
  logic [14:0] ram_off;
  logic        ram_blocked;
  logic        rom_bank_upd;
  logic        ram_bank_upd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference model state
  logic [4:0] m_bank;
  logic [1:0] m_field;
  logic       m_mode;
  logic       m_ram_en;

  always #2 clk = ~clk;

  cart_bank_ctrl dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .rom_size(rom_size), .rom_hit(rom_hit), .rom_off(rom_off),
    .rom_zero(rom_zero), .ram_hit(ram_hit), .ram_off(ram_off), .ram_blocked(ram_blocked),
    .rom_bank_upd(rom_bank_upd), .ram_bank_upd(ram_bank_upd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] exp_rom(input logic [15:0] a);
    if (a[15:14] == 2'b00) return {7'd0, a[13:0]};
    return {(m_mode ? 2'b00 : m_field), m_bank, a[13:0]};
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    case (a[15:13])
      3'b000: m_ram_en = (d[3:0] == 4'hA);
      3'b001: m_bank   = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
      3'b010: m_field  = d[1:0];
      3'b011: m_mode   = d[0];
      default: ;
    endcase
    chk(rom_bank_upd == (a[15:13] == 3'b001), "R2 bank pulse", 32'(rom_bank_upd), 32'(a[15:13] == 3'b001));
    chk(ram_bank_upd == (a[15:13] == 3'b010), "R3 field pulse", 32'(ram_bank_upd), 32'(a[15:13] == 3'b010));
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [20:0] e;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    if (a[15] == 1'b0) begin
      e = exp_rom(a);
      chk(rom_hit && !ram_hit, {tag, " hit"}, 32'({rom_hit, ram_hit}), 32'h2);
      chk(rom_off == e, {tag, " offset"}, 32'(rom_off), 32'(e));
      chk(rom_zero == ({1'b0, e} >= rom_size), "R7 zero flag", 32'(rom_zero), 32'({1'b0, e} >= rom_size));
    end else if (a[15:13] == 3'b101) begin
      chk(ram_hit && !rom_hit, "R9 hit", 32'({rom_hit, ram_hit}), 32'h1);
      chk(ram_off == {(m_mode ? m_field : 2'b00), a[12:0]}, "R9 offset", 32'(ram_off),
          32'({(m_mode ? m_field : 2'b00), a[12:0]}));
      chk(ram_blocked == !m_ram_en, "R8 R9 blocked", 32'(ram_blocked), 32'(!m_ram_en));
    end else begin
      chk({rom_hit, ram_hit, rom_zero, ram_blocked} == 4'b0, "R10 no target",
          32'({rom_hit, ram_hit, rom_zero, ram_blocked}), 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra;
    void'($urandom(32'd4242));
    rst = 1'b1; cpu_addr = '0; cpu_wr = 0; cpu_rd = 0; cpu_wdata = '0;
    rom_size = 22'h200000;
    m_bank = 5'd1; m_field = 2'd0; m_mode = 1'b0; m_ram_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the outputs and through reads
    chk({rom_hit, rom_zero, ram_hit, ram_blocked, rom_bank_upd, ram_bank_upd} == 6'b0 &&
        rom_off == '0 && ram_off == '0, "R1 outputs", 32'(rom_off), 32'h0);
    do_read(16'h4123, "R1 R6 reset bank");
    do_read(16'hA010, "R1 R9 reset ram");

    // Directed corners
    do_read(16'h3FFF, "R5 fixed");
    do_write(16'h2000, 8'h00); do_read(16'h4000, "R2 zero bank");
    do_write(16'h3FFF, 8'hE0); do_read(16'h7FFF, "R2 upper bits ignored");
    do_write(16'h2100, 8'h1F); do_read(16'h5555, "R2 bank 31");
    do_write(16'h4000, 8'hFE); do_read(16'h6001, "R3 R6 field in rom");
    do_write(16'h6000, 8'h01); do_read(16'h6001, "R4 R6 ram mode");
    do_write(16'h0000, 8'h1A); do_read(16'hBFFF, "R8 R9 enabled");
    do_write(16'h1FFF, 8'hA0); do_read(16'hA000, "R8 R9 disabled");
    do_write(16'h0A00, 8'h0A); do_read(16'hA000, "R8 R9 reenabled");
    do_write(16'h7000, 8'h00); do_read(16'hB123, "R4 R9 rom mode");
    do_read(16'h8000, "R10 video");
    do_read(16'hC000, "R10 work ram");

    // Size boundary at 256 KB
    @(negedge clk); rom_size = 22'h040000;
    do_write(16'h4000, 8'h00);
    do_write(16'h2000, 8'h0F); do_read(16'h7FFF, "R7 R6 last byte");
    do_write(16'h2000, 8'h10); do_read(16'h4000, "R7 R6 first oob");
    do_write(16'h5000, 8'h01); do_write(16'h2000, 8'h02); do_read(16'h4000, "R7 R6 field oob");
    do_write(16'h6000, 8'h01); do_read(16'h4000, "R7 R4 ram mode in range");

    // Constrained random under both sizes
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk); rom_size = (pass == 0) ? 22'h200000 : 22'h040000;
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 2) == 0)
          do_write(16'($urandom_range(0, 16'h7FFF)), 8'($urandom()));
        else begin
          ra = 16'($urandom());
          do_read(ra, "R6 random");
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule